// File: doc/BRIEF.md
# Byte and Block Fill Controller for a Non-Volatile Data Array

This block sits between a simple register bus and a 512-byte non-volatile data array. It can read or write a single byte. It can also write one value across a whole 64-byte row, or across the entire array. Filling with 00h is how a row or the full array is erased. The array port uses a request/ready handshake, so a slow array can stretch each access for as long as it needs.

Software loads an address, loads a data value, and then writes a command. The controller works out the first and last address that the command covers and walks through them one byte at a time in ascending order. After the last access it raises a completion flag that is shared by all four operations. If the interrupt is enabled, the flag drives the interrupt output. Software clears the flag explicitly.

Registers are selected by `regSel`:

| Select | Write effect | Read value |
|---|---|---|
| 0 | address bits [7:0] | address bits [7:0] |
| 1 | address bit 8 (data bit 0) | address bit 8 (in bit 0) |
| 2 | data / fill value | byte-read result, or the status byte while busy |
| 3 | command word | status byte |

Command word fields:

| Bit(s) | Meaning |
|---|---|
| 7 | start an operation |
| 6 | clear the completion flag when set to 1 |
| 5 | interrupt enable; stored on every command write |
| 1:0 | operation: 0 = read, 1 = write, 2 = row fill, 3 = sector fill |

Status byte fields:

| Bit | Meaning |
|---|---|
| 7 | busy |
| 6 | completion flag |
| 5 | interrupt enable |
| 4:0 | zero |

Top module: `nvfill_ctrl`

## Requirements
- R1: After reset the status byte (select 3) reads 00h, address select 0 reads 00h, `irq` is 0 and `arrReq` is 0.
- R2: A command with bit 7 set and op 1 writes the data register value to the addressed byte with exactly one array write, leaving other bytes unchanged.
- R3: A command with bit 7 set and op 0 reads the addressed byte. Once the controller is idle, select 2 returns that byte, and no array write takes place.
- R4: Op 2 writes the fill value to all 64 bytes from (address with bits [5:0] cleared) up to that base plus 63, in ascending order, and touches no byte outside that row.
- R5: Op 3 writes the fill value to all 512 bytes in ascending order from 000h; a fill value of 00h leaves every byte at zero.
- R6: Each array access holds `arrReq`, `arrAddr` and `arrWdata` steady until `arrReady` is seen, so every access lasts at least one cycle more than the array's wait count.
- R7: Status bit 7 reads 1 from the cycle after a start command is accepted until the cycle after the last handshake. A start command written while busy is ignored.
- R8: While busy, a read of select 2 returns the status byte instead of read data.
- R9: Status bit 6 is set when any operation finishes and cleared by a command write with bit 6 set. When both happen in the same cycle, the flag ends up set.
- R10: `irq` equals status bit 6 AND status bit 5. Bit 5 takes command bit 5 on every command write, including one made while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rstN | input | 1 | active-low asynchronous reset |
| regSel | input | 2 | register select |
| regWr | input | 1 | register write strobe |
| regWdata | input | 8 | register write data |
| regRdata | output | 8 | register read data for `regSel` |
| arrReq | output | 1 | array access request |
| arrWe | output | 1 | array access is a write |
| arrAddr | output | 9 | array byte address |
| arrWdata | output | 8 | array write data |
| arrRdata | input | 8 | array read data for `arrAddr` |
| arrReady | input | 1 | array completes the pending access this cycle |
| irq | output | 1 | completion interrupt |

## Verification
The final array handshake and a software write that clears the completion flag can land on the same clock edge. In that case the finish must win and the flag must stay set. To provoke this, the array model holds `arrReady` low during a byte write. The bench then raises `arrReady` on the same edge as a command write with the clear bit set. Immediately afterwards it checks that the status reads idle with the flag and interrupt still active, and that exactly one array write took place. A start command issued during the same stall must not produce any further accesses.

// File: rtl/nvfill_pkg.sv
package nvfill_pkg;

  typedef enum logic [1:0] {
    OP_READ   = 2'd0,
    OP_WRITE  = 2'd1,
    OP_ROW    = 2'd2,
    OP_SECTOR = 2'd3
  } fillOp_e;

  // strobes from control to datapath
  typedef struct packed {
    logic start;
    logic advance;
    logic capture;
    logic finish;
  } seqStrobe_t;

  localparam logic [1:0] SEL_ADDR_LO = 2'd0;
  localparam logic [1:0] SEL_ADDR_HI = 2'd1;
  localparam logic [1:0] SEL_DATA    = 2'd2;
  localparam logic [1:0] SEL_CMD     = 2'd3;

  localparam int BIT_GO  = 7;
  localparam int BIT_CLR = 6;
  localparam int BIT_IEN = 5;

endpackage

// File: rtl/nvfill_datapath.sv
module nvfill_datapath
  import nvfill_pkg::*;
#(
  parameter int AW = 9,
  parameter int DW = 8,
  parameter int ROW_BITS = 6
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [1:0]    regSel,
  input  logic          regWr,
  input  logic [DW-1:0] regWdata,
  output logic [DW-1:0] regRdata,
  input  logic          busy,
  input  seqStrobe_t    seq,
  output logic          cmdValid,
  output fillOp_e       cmdOp,
  output logic          atLast,
  output logic [AW-1:0] arrAddr,
  output logic [DW-1:0] arrWdata,
  input  logic [DW-1:0] arrRdata,
  output logic          irq
);

  localparam logic [AW-1:0] ROW_MASK = AW'((1 << ROW_BITS) - 1);

  logic [DW-1:0] addrLo;
  logic [AW-1:0] addrReg;
  logic [DW-1:0] hiByte;
  logic [DW-1:0] dataReg;
  logic [DW-1:0] fillVal;
  logic [DW-1:0] rdBuf;
  logic [AW-1:0] curAddr;
  logic [AW-1:0] lastAddr;
  logic [AW-1:0] spanLo;
  logic [AW-1:0] spanHi;
  logic          doneFlag;
  logic          irqEn;
  logic          cmdWrite;
  logic [DW-1:0] statusByte;

  assign cmdWrite = regWr && (regSel == SEL_CMD);
  assign cmdValid = cmdWrite && regWdata[BIT_GO];
  assign cmdOp    = fillOp_e'(regWdata[1:0]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrLo  <= '0;
      dataReg <= '0;
    end else if (regWr) begin
      if (regSel == SEL_ADDR_LO) addrLo  <= regWdata;
      if (regSel == SEL_DATA)    dataReg <= regWdata;
    end
  end

  generate
    if (AW > DW) begin : g_hi
      logic [AW-DW-1:0] addrHi;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) addrHi <= '0;
        else if (regWr && regSel == SEL_ADDR_HI) addrHi <= regWdata[AW-DW-1:0];
      end
      assign addrReg = {addrHi, addrLo};
      assign hiByte  = DW'(addrHi);
    end else begin : g_lo
      assign addrReg = addrLo[AW-1:0];
      assign hiByte  = '0;
    end
  endgenerate

  // address span covered by the incoming command
  always_comb begin
    unique case (cmdOp)
      OP_ROW: begin
        spanLo = addrReg & ~ROW_MASK;
        spanHi = addrReg | ROW_MASK;
      end
      OP_SECTOR: begin
        spanLo = '0;
        spanHi = '1;
      end
      default: begin
        spanLo = addrReg;
        spanHi = addrReg;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curAddr  <= '0;
      lastAddr <= '0;
      fillVal  <= '0;
      rdBuf    <= '0;
    end else begin
      if (seq.start) begin
        curAddr  <= spanLo;
        lastAddr <= spanHi;
        fillVal  <= dataReg;
      end else if (seq.advance) begin
        curAddr <= curAddr + 1'b1;
      end
      if (seq.capture) rdBuf <= arrRdata;
    end
  end

  // completion flag: a finish outranks a software clear in the same cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      doneFlag <= 1'b0;
      irqEn    <= 1'b0;
    end else begin
      if (seq.finish) doneFlag <= 1'b1;
      else if (cmdWrite && regWdata[BIT_CLR]) doneFlag <= 1'b0;
      if (cmdWrite) irqEn <= regWdata[BIT_IEN];
    end
  end

  always_comb begin
    statusByte          = '0;
    statusByte[BIT_GO]  = busy;
    statusByte[BIT_CLR] = doneFlag;
    statusByte[BIT_IEN] = irqEn;
  end

  always_comb begin
    unique case (regSel)
      SEL_ADDR_LO: regRdata = addrReg[DW-1:0];
      SEL_ADDR_HI: regRdata = hiByte;
      SEL_DATA:    regRdata = busy ? statusByte : rdBuf;
      default:     regRdata = statusByte;
    endcase
  end

  assign atLast   = (curAddr == lastAddr);
  assign arrAddr  = curAddr;
  assign arrWdata = fillVal;
  assign irq      = doneFlag && irqEn;

  // R9: the final access leaves the flag set even against a clear
  a_r9_finish_sets_flag: assert property (@(posedge clk) disable iff (!rstN)
    seq.finish |=> doneFlag);

  // R4: the walk never passes the end of its span
  a_r4_within_span: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (curAddr <= lastAddr));

endmodule

// File: rtl/nvfill_control.sv
module nvfill_control
  import nvfill_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  fillOp_e    cmdOp,
  input  logic       atLast,
  input  logic       arrReady,
  output logic       busy,
  output logic       arrReq,
  output logic       arrWe,
  output seqStrobe_t seq
);

  typedef enum logic {S_IDLE, S_RUN} seqState_e;

  seqState_e state;
  fillOp_e   opReg;
  logic      handshake;

  assign busy      = (state == S_RUN);
  assign arrReq    = busy;
  assign arrWe     = (opReg != OP_READ);
  assign handshake = arrReq && arrReady;

  always_comb begin
    seq.start   = cmdValid && !busy;
    seq.advance = handshake && !atLast;
    seq.finish  = handshake && atLast;
    seq.capture = handshake && (opReg == OP_READ);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      opReg <= OP_READ;
    end else if (seq.start) begin
      state <= S_RUN;
      opReg <= cmdOp;
    end else if (seq.finish) begin
      state <= S_IDLE;
    end
  end

  // R6: a request is never withdrawn before the array answers
  a_r6_req_waits: assert property (@(posedge clk) disable iff (!rstN)
    (arrReq && !arrReady) |=> arrReq);

  // R7: a start command during an operation changes nothing
  a_r7_busy_ignores_cmd: assert property (@(posedge clk) disable iff (!rstN)
    (busy && cmdValid) |=> (opReg == $past(opReg)));

endmodule

// File: rtl/nvfill_ctrl.sv
module nvfill_ctrl
  import nvfill_pkg::*;
#(
  parameter int AW = 9,
  parameter int DW = 8,
  parameter int ROW_BITS = 6
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [1:0]    regSel,
  input  logic          regWr,
  input  logic [DW-1:0] regWdata,
  output logic [DW-1:0] regRdata,
  output logic          arrReq,
  output logic          arrWe,
  output logic [AW-1:0] arrAddr,
  output logic [DW-1:0] arrWdata,
  input  logic [DW-1:0] arrRdata,
  input  logic          arrReady,
  output logic          irq
);

  seqStrobe_t seq;
  logic       busy;
  logic       cmdValid;
  fillOp_e    cmdOp;
  logic       atLast;

  nvfill_control u_control (
    .clk      (clk),
    .rstN     (rstN),
    .cmdValid (cmdValid),
    .cmdOp    (cmdOp),
    .atLast   (atLast),
    .arrReady (arrReady),
    .busy     (busy),
    .arrReq   (arrReq),
    .arrWe    (arrWe),
    .seq      (seq)
  );

  nvfill_datapath #(.AW(AW), .DW(DW), .ROW_BITS(ROW_BITS)) u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .regSel   (regSel),
    .regWr    (regWr),
    .regWdata (regWdata),
    .regRdata (regRdata),
    .busy     (busy),
    .seq      (seq),
    .cmdValid (cmdValid),
    .cmdOp    (cmdOp),
    .atLast   (atLast),
    .arrAddr  (arrAddr),
    .arrWdata (arrWdata),
    .arrRdata (arrRdata),
    .irq      (irq)
  );

  // R6: address and data stay put while the array stalls
  a_r6_addr_hold: assert property (@(posedge clk) disable iff (!rstN)
    (arrReq && !arrReady) |=> (arrReq && $stable(arrAddr) && $stable(arrWdata)));

  // R4: consecutive accesses of one operation climb by one
  a_r4_ascending: assert property (@(posedge clk) disable iff (!rstN)
    (arrReq && arrReady) |=> (!arrReq || arrAddr == $past(arrAddr) + 1'b1));

  // R7: busy only begins from a start command on the bus
  a_r7_busy_from_cmd: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(regWr && regSel == SEL_CMD && regWdata[BIT_GO]));

  // R9: an operation only ends on an array handshake
  a_r9_end_on_handshake: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $past(arrReq && arrReady));

endmodule

// File: tb/nvfill_ctrl_test.sv
module nvfill_ctrl_test;

  localparam int AW = 9;
  localparam int CLK_NS = 20;
  localparam logic [1:0] S_LO = 2'd0, S_HI = 2'd1, S_DATA = 2'd2, S_CMD = 2'd3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] regSel = 2'd0;
  logic regWr = 1'b0;
  logic [7:0] regWdata = 8'h00;
  logic [7:0] regRdata;
  logic arrReq, arrWe, arrReady, irq;
  logic [AW-1:0] arrAddr;
  logic [7:0] arrWdata, arrRdata;

  // array model
  logic [7:0] mem [512];
  int delay = 0;
  int waitCnt = 0;
  logic holdRdy = 1'b0;
  logic forceRdy = 1'b0;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  int writeCnt = 0;
  int orderErr = 0;
  int holdErr = 0;
  logic [AW-1:0] expNext = '0;
  logic [AW-1:0] prevAddr = '0;
  logic prevStall = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  nvfill_ctrl uut (
    .clk(clk), .rstN(rstN), .regSel(regSel), .regWr(regWr), .regWdata(regWdata),
    .regRdata(regRdata), .arrReq(arrReq), .arrWe(arrWe), .arrAddr(arrAddr),
    .arrWdata(arrWdata), .arrRdata(arrRdata), .arrReady(arrReady), .irq(irq)
  );

  assign arrReady = arrReq && (holdRdy ? forceRdy : (waitCnt == delay));
  assign arrRdata = mem[arrAddr];

  always @(posedge clk) begin
    if (arrReq && !arrReady) waitCnt <= waitCnt + 1;
    else waitCnt <= 0;
    if (arrReq && arrReady && arrWe) mem[arrAddr] = arrWdata;
  end

  // port monitor, sampled mid-low-phase
  always @(negedge clk) begin
    #5;
    if (prevStall && arrAddr != prevAddr) holdErr++;
    prevStall = arrReq && !arrReady;
    prevAddr = arrAddr;
    if (arrReq && arrReady && arrWe) begin
      writeCnt++;
      if (arrAddr != expNext) orderErr++;
      expNext = arrAddr + 1'b1;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      failures++;
      $display("FAIL watchdog (all requirements): actual=%0d expected<=100000 cycles", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  function automatic logic [7:0] pat(int i);
    return 8'(i) ^ 8'h5A;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic regWrite(logic [1:0] sel, logic [7:0] d);
    @(negedge clk);
    regSel = sel; regWdata = d; regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic regRead(logic [1:0] sel, output logic [7:0] d);
    regSel = sel;
    #2;
    d = regRdata;
  endtask

  task automatic waitIdle(output int cyc);
    cyc = 0;
    do begin
      @(negedge clk);
      regSel = S_CMD;
      #2;
      cyc++;
    end while (regRdata[7] && cyc < 5000);
    #8;
  endtask

  task automatic setAddr(logic [AW-1:0] a);
    regWrite(S_LO, a[7:0]);
    regWrite(S_HI, {7'b0, a[8]});
  endtask

  task automatic t_reset();
    logic [7:0] d;
    regRead(S_CMD, d);
    check(d == 8'h00, "R1", "status after reset", d, 8'h00);
    regRead(S_LO, d);
    check(d == 8'h00, "R1", "address after reset", d, 8'h00);
    check(irq == 1'b0 && arrReq == 1'b0, "R1", "irq/arrReq after reset", {irq, arrReq}, 0);
  endtask

  task automatic t_byte_write();
    int cyc;
    delay = 1;
    setAddr(9'h134);
    regWrite(S_DATA, 8'hA7);
    writeCnt = 0; orderErr = 0; expNext = 9'h134;
    regWrite(S_CMD, 8'h81);
    waitIdle(cyc);
    check(mem[9'h134] == 8'hA7, "R2", "byte written", mem[9'h134], 8'hA7);
    check(mem[9'h133] == pat(9'h133) && mem[9'h135] == pat(9'h135), "R2", "neighbours intact",
          {mem[9'h133], mem[9'h135]}, {pat(9'h133), pat(9'h135)});
    check(writeCnt == 1 && orderErr == 0, "R2", "single write", writeCnt, 1);
  endtask

  task automatic t_byte_read();
    int cyc;
    logic [7:0] d;
    delay = 2;
    setAddr(9'h0A5);
    writeCnt = 0;
    regWrite(S_CMD, 8'h80);
    waitIdle(cyc);
    regRead(S_DATA, d);
    check(d == pat(9'h0A5), "R3", "read data", d, pat(9'h0A5));
    check(writeCnt == 0, "R3", "no write on read", writeCnt, 0);
  endtask

  task automatic t_row_fill();
    int cyc;
    int bad;
    logic [7:0] d;
    delay = 2;
    setAddr(9'h0C5);
    regWrite(S_DATA, 8'h77);
    writeCnt = 0; orderErr = 0; holdErr = 0; expNext = 9'h0C0;
    regWrite(S_CMD, 8'h82);
    regRead(S_CMD, d);
    check(d[7] == 1'b1, "R7", "busy after accept", d[7], 1);
    waitIdle(cyc);
    bad = 0;
    for (int i = 9'h0C0; i <= 9'h0FF; i++) if (mem[i] != 8'h77) bad++;
    check(bad == 0, "R4", "row bytes filled", bad, 0);
    check(mem[9'h0BF] == pat(9'h0BF) && mem[9'h100] == pat(9'h100), "R4", "outside row intact",
          {mem[9'h0BF], mem[9'h100]}, {pat(9'h0BF), pat(9'h100)});
    check(writeCnt == 64 && orderErr == 0, "R4", "64 ascending writes", writeCnt, 64);
    check(holdErr == 0, "R6", "address held during stall", holdErr, 0);
    check(cyc >= 64 * 3, "R6", "each access waits for ready", cyc, 192);
  endtask

  task automatic t_sector();
    int cyc;
    int bad;
    delay = 0;
    regWrite(S_DATA, 8'hE1);
    writeCnt = 0; orderErr = 0; expNext = '0;
    regWrite(S_CMD, 8'h83);
    waitIdle(cyc);
    bad = 0;
    for (int i = 0; i < 512; i++) if (mem[i] != 8'hE1) bad++;
    check(bad == 0 && writeCnt == 512 && orderErr == 0, "R5", "sector fill E1", bad + writeCnt, 512);
    regWrite(S_DATA, 8'h00);
    writeCnt = 0; orderErr = 0; expNext = '0;
    regWrite(S_CMD, 8'h83);
    waitIdle(cyc);
    bad = 0;
    for (int i = 0; i < 512; i++) if (mem[i] != 8'h00) bad++;
    check(bad == 0 && writeCnt == 512 && orderErr == 0, "R5", "sector erase", bad + writeCnt, 512);
  endtask

  task automatic t_done_irq();
    int cyc;
    logic [7:0] d;
    regRead(S_CMD, d);
    check(d == 8'h40, "R9", "flag set after fill", d, 8'h40);
    regWrite(S_CMD, 8'h40);
    regRead(S_CMD, d);
    check(d == 8'h00, "R9", "flag cleared", d, 8'h00);
    regWrite(S_CMD, 8'h20);
    check(irq == 1'b0, "R10", "no irq without flag", irq, 0);
    setAddr(9'h020);
    regWrite(S_DATA, 8'h3C);
    regWrite(S_CMD, 8'hA1);
    waitIdle(cyc);
    check(irq == 1'b1, "R10", "irq on completion", irq, 1);
    regWrite(S_CMD, 8'h00);
    regRead(S_CMD, d);
    check(irq == 1'b0 && d == 8'h40, "R10", "irq masked, flag kept", {irq, d}, 8'h40);
    regWrite(S_CMD, 8'h40);
  endtask

  task automatic t_collision();
    logic [7:0] d;
    holdRdy = 1'b1; forceRdy = 1'b0;
    setAddr(9'h010);
    regWrite(S_DATA, 8'h5C);
    writeCnt = 0; orderErr = 0; expNext = 9'h010;
    regWrite(S_CMD, 8'hA1);
    regRead(S_CMD, d);
    check(d == 8'hA0, "R7", "busy while stalled", d, 8'hA0);
    regRead(S_DATA, d);
    check(d == 8'hA0, "R8", "data select shows status", d, 8'hA0);
    regWrite(S_CMD, 8'hA3);
    repeat (3) @(negedge clk);
    forceRdy = 1'b1;
    regSel = S_CMD; regWdata = 8'h60; regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0; forceRdy = 1'b0;
    regRead(S_CMD, d);
    check(d == 8'h60, "R9", "finish beats clear", d, 8'h60);
    check(irq == 1'b1, "R10", "irq after collision", irq, 1);
    repeat (6) @(negedge clk);
    #8;
    check(writeCnt == 1 && arrReq == 1'b0, "R7", "command while busy ignored", writeCnt, 1);
    check(mem[9'h010] == 8'h5C && mem[9'h011] == 8'h00, "R2", "collision write result",
          {mem[9'h010], mem[9'h011]}, 16'h5C00);
    holdRdy = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < 512; i++) mem[i] = pat(i);
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_byte_write();
    t_byte_read();
    t_row_fill();
    t_sector();
    t_done_irq();
    t_collision();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule